// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block produces the system reset for a chip from three sources: a digital supply-good flag, an active-low pushbutton and a watchdog that software must keep strobing. Any of these sources raises a single stretched reset. The reset is driven out as an active-high and an active-low pair that are always complements of each other. Supply loss acts almost at once. A pushbutton press counts only after it has stayed low for a qualification time. A missing strobe trips the watchdog after one of three selectable timeouts. The watchdog cannot be turned off.

All timing comes from one free-running prescaler that makes a one-clock tick every `CLKS_PER_MS` clocks. Each duration is a parameter expressed in ticks, so a testbench can shrink every interval to a few cycles. The strobe, pushbutton and supply-good inputs each pass through a two-flop synchroniser. The strobe is acted on at its synchronised rising edge, so a pulse one clock long is enough.

Top module: `wd_reset_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1 and `sys_rst_n` is 0. In every cycle, `sys_rst_n` equals the inverse of `sys_rst`.
- R2: When `pwr_ok` falls, `sys_rst` is still 0 after the second rising clock edge and is 1 after the third. It stays 1 for as long as `pwr_ok` is low.
- R3: After a watchdog or pushbutton trigger has ended, reset stays asserted for `HOLD_MS` ticks and is then released on a tick.
- R4: When `pwr_ok` returns, the hold time restarts from the return, so reset releases `HOLD_MS` ticks after `pwr_ok` is seen high again.
- R5: `pb_n` raises reset only once it has been sampled low on `PB_MS` ticks in a row. Any high sample clears the qualification count, so shorter presses have no effect on `sys_rst`.
- R6: The watchdog fires when `WD_LO_MS`, `WD_MID_MS` or `WD_HI_MS` ticks pass without a strobe edge, for `wd_sel` equal to 2'b00, 2'b01 or 2'b10 respectively. The value 2'b11 selects `WD_MID_MS`.
- R7: Each synchronised rising edge of `wd_strobe` restarts the watchdog count. A strobe high for a single clock counts as an edge. Strobes spaced closer than the timeout keep reset low.
- R8: The watchdog has no disable input. Its count is held at zero while reset is asserted, so each timeout after a release is measured in full from that release.
- R9: The prescaler runs freely from the end of `rst_n` and produces one tick every `CLKS_PER_MS` clocks. All of the counts above advance only on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| pwr_ok | input | 1 | Supply-good flag from the supply comparator (asynchronous) |
| pb_n | input | 1 | Pushbutton, active low (asynchronous) |
| wd_strobe | input | 1 | Watchdog strobe; rising edges restart the watchdog |
| wd_sel | input | 2 | Timeout select: 00 short, 01 medium, 10 long, 11 medium |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Supply loss needs exactly three clock edges to reach `sys_rst`: two for the synchroniser and one for the reset register. The bench samples before and after the third edge. Pushbutton and watchdog results depend on where the prescaler phase falls. They are due within one tick, plus three clocks of synchronisation and register delay, of the nominal tick count. The directed checks therefore use windows of that width. A behavioural model in the bench advances the prescaler, the counters and the reset state each clock, and it is compared with both outputs on every falling edge. Timing errors that fall inside a window are still caught by this per-cycle comparison.

// File: rtl/wd_reset_supervisor.sv
module wd_reset_supervisor #(
  parameter int CLKS_PER_MS = 50000,
  parameter int WD_LO_MS    = 150,
  parameter int WD_MID_MS   = 610,
  parameter int WD_HI_MS    = 1200,
  parameter int HOLD_MS     = 610,
  parameter int PB_MS       = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       pb_n,
  input  logic       wd_strobe,
  input  logic [1:0] wd_sel,
  output logic       sys_rst,
  output logic       sys_rst_n
);
  localparam int WD_MAX = (WD_HI_MS > WD_MID_MS) ?
                          ((WD_HI_MS > WD_LO_MS) ? WD_HI_MS : WD_LO_MS) :
                          ((WD_MID_MS > WD_LO_MS) ? WD_MID_MS : WD_LO_MS);
  localparam int PW = $clog2(CLKS_PER_MS + 1);
  localparam int WW = $clog2(WD_MAX + 1);
  localparam int HW = $clog2(HOLD_MS + 1);
  localparam int BW = $clog2(PB_MS + 1);

  logic [1:0]    pwr_sy, pb_sy;
  logic [2:0]    stb_sy;
  logic [PW-1:0] presc;
  logic [BW-1:0] pb_cnt;
  logic [WW-1:0] wd_cnt, wd_lim;
  logic [HW-1:0] hold_cnt;
  logic          rst_q;

  wire tick     = presc == PW'(CLKS_PER_MS - 1);
  wire pwr_s    = pwr_sy[1];
  wire pb_s     = pb_sy[1];
  wire stb_edge = stb_sy[1] & ~stb_sy[2];
  wire pb_hit   = pb_cnt == BW'(PB_MS);
  wire wd_hit   = wd_cnt >= wd_lim;
  wire trig     = ~pwr_s | pb_hit | wd_hit;

  always_comb begin
    case (wd_sel)
      2'b00:   wd_lim = WW'(WD_LO_MS);
      2'b10:   wd_lim = WW'(WD_HI_MS);
      default: wd_lim = WW'(WD_MID_MS);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_sy <= 2'b00;
      pb_sy  <= 2'b11;
      stb_sy <= 3'b000;
    end else begin
      pwr_sy <= {pwr_sy[0], pwr_ok};
      pb_sy  <= {pb_sy[0], pb_n};
      stb_sy <= {stb_sy[1:0], wd_strobe};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    presc <= '0;
    else if (tick) presc <= '0;
    else           presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pb_cnt <= '0;
    else if (pb_s)             pb_cnt <= '0;
    else if (tick && !pb_hit)  pb_cnt <= pb_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           wd_cnt <= '0;
    else if (rst_q || stb_edge || wd_hit) wd_cnt <= '0;
    else if (tick)                        wd_cnt <= wd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (trig) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_q && tick) begin
      if (hold_cnt == HW'(HOLD_MS - 1)) begin
        rst_q    <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  assign sys_rst   = rst_q;
  assign sys_rst_n = ~rst_q;

  // R2
  pwr_loss_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_s |=> rst_q);
  // R5
  pb_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_hit |=> rst_q);
  // R6
  wd_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hit |=> rst_q);
  // R7
  stb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_edge |=> wd_cnt == '0);
  // R8
  wd_idle_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> wd_cnt == '0);
  // R3
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> pwr_s && $past(tick));
endmodule

// File: tb/wd_reset_supervisor_test.sv
module wd_reset_supervisor_test;
  localparam int CPM = 4, LO = 5, MID = 8, HI = 12, HOLD = 6, PB = 3;

  logic clk = 0, rst_n = 0, pwr_ok = 0, pb_n = 1, wd_strobe = 0;
  logic [1:0] wd_sel = 2'b00;
  logic sys_rst, sys_rst_n;
  logic stb_on = 0;
  int   nchk = 0, nfail = 0, cyc = 0;

  always #10 clk = ~clk;

  wd_reset_supervisor #(.CLKS_PER_MS(CPM), .WD_LO_MS(LO), .WD_MID_MS(MID),
    .WD_HI_MS(HI), .HOLD_MS(HOLD), .PB_MS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .pb_n(pb_n),
    .wd_strobe(wd_strobe), .wd_sel(wd_sel), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_p, m_pb, m_wd, m_hold, m_rst;
  bit p1, p2, b1, b2, s1, s2, s3;
  function automatic int lim_of(input logic [1:0] s);
    return (s == 2'b00) ? LO : (s == 2'b10) ? HI : MID;
  endfunction
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p = 0; m_pb = 0; m_wd = 0; m_hold = 0; m_rst = 1;
      p1 = 0; p2 = 0; b1 = 1; b2 = 1; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit tk, edge_s, pbh, wdh, tr;
      tk = (m_p == CPM - 1);
      edge_s = s2 && !s3;
      pbh = (m_pb == PB);
      wdh = (m_wd >= lim_of(wd_sel));
      tr = !p2 || pbh || wdh;
      m_p = tk ? 0 : m_p + 1;
      if (b2) m_pb = 0; else if (tk && !pbh) m_pb++;
      if (m_rst != 0 || edge_s || wdh) m_wd = 0; else if (tk) m_wd++;
      if (tr) begin m_rst = 1; m_hold = 0; end
      else if (m_rst != 0 && tk) begin
        if (m_hold == HOLD - 1) begin m_rst = 0; m_hold = 0; end else m_hold++;
      end
      p2 = p1; p1 = pwr_ok; b2 = b1; b1 = pb_n; s3 = s2; s2 = s1; s1 = wd_strobe;
    end
  end

  // per-cycle compare; R9 tick spacing and all counts are checked through the model
  always @(negedge clk) begin
    cyc++;
    chk(sys_rst === 1'(m_rst), "R9 model compare sys_rst", int'(sys_rst), m_rst);
    chk(sys_rst_n === ~sys_rst, "R1 complement", int'(sys_rst_n), int'(~sys_rst));
    if (cyc > 150000) begin
      chk(0, "watchdog expired", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // strobe generator: one-clock pulse every 8 clocks when enabled
  int sc = 0;
  always @(negedge clk) begin
    sc = (sc + 1) % 8;
    wd_strobe <= stb_on && (sc == 0);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_level(input bit lvl, input int cap, output int n);
    n = 0;
    while (sys_rst !== lvl && n < cap) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    run(5);
    chk(sys_rst === 1 && sys_rst_n === 0, "R1 reset state", int'(sys_rst), 1);
    rst_n = 1;
    run(30);
    chk(sys_rst === 1, "R2 held while supply low", int'(sys_rst), 1);

    stb_on = 1; pwr_ok = 1;
    wait_level(0, 200, n);
    chk(n >= (HOLD - 1) * CPM && n <= HOLD * CPM + 4, "R4 release after return", n, HOLD * CPM);

    for (int s = 0; s < 4; s++) begin
      wd_sel = 2'(s);
      run(150);
      chk(sys_rst === 0, "R7 strobing holds off reset", int'(sys_rst), 0);
    end

    for (int s = 0; s < 4; s++) begin
      int lim;
      wd_sel = 2'(s);
      lim = lim_of(2'(s));
      stb_on = 0;
      wait_level(1, 200, n);
      chk(n >= (lim - 1) * CPM - 8 && n <= lim * CPM + 8, "R6 timeout per select", n, lim * CPM);
      wait_level(0, 200, n);
      chk(n >= (HOLD - 1) * CPM && n <= HOLD * CPM + 2, "R3 hold after watchdog", n, HOLD * CPM);
      wait_level(1, 200, n);
      chk(n >= (lim - 1) * CPM && n <= lim * CPM + 4, "R8 full timeout from release", n, lim * CPM);
      stb_on = 1;
      wait_level(0, 200, n);
      run(4);
    end

    wd_sel = 2'b01;
    pb_n = 0; run(6); pb_n = 1;
    run(20);
    chk(sys_rst === 0, "R5 short press ignored", int'(sys_rst), 0);
    pb_n = 0; run(8);
    chk(sys_rst === 0, "R5 not yet qualified", int'(sys_rst), 0);
    run(12);
    chk(sys_rst === 1, "R5 qualified press resets", int'(sys_rst), 1);
    run(20);
    chk(sys_rst === 1, "R5 held while pressed", int'(sys_rst), 1);
    pb_n = 1;
    wait_level(0, 200, n);
    chk(n >= (HOLD - 1) * CPM && n <= HOLD * CPM + 4, "R3 hold after button", n, HOLD * CPM);

    run(3);
    pwr_ok = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(sys_rst === 0, "R2 not before third edge", int'(sys_rst), 0);
    @(negedge clk);
    chk(sys_rst === 1, "R2 asserted at third edge", int'(sys_rst), 1);
    run(10);
    pwr_ok = 1;
    run((HOLD - 1) * CPM);
    chk(sys_rst === 1, "R4 still held from return", int'(sys_rst), 1);
    run(CPM + 6);
    chk(sys_rst === 0, "R4 released after return", int'(sys_rst), 0);

    run(20);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule